// File: doc/BRIEF.md
# Nine-Level Phase-Disposition Gate Modulator

This block turns a signed sinusoidal reference sample into gate commands for a single-phase nine-level inverter. The inverter has seven switches and four DC sources and no H-bridge. A single triangle counter drives eight carriers that are stacked in phase. Four carriers sit in bands above zero and four sit below it. On every clock the reference is compared with all eight carriers. The comparison yields a signed level between -4 and +4 DC steps.

The level is registered and may change by at most one step per clock. A fixed seven-bit pattern per level switches the sources in. Polarity is set by one of two dedicated switches. Switches that are turning on are delayed by a programmable dead time. Switches that are turning off drop at once. Holding enable low (or asserting reset) parks the block with every gate off and the level at zero.

Top module: `mlpwm_top`

## Requirements
- R1: While reset is asserted, and one clock after enable is sampled low, `levelCode` is 0 and all seven gate bits are 0.
- R2: With band height P (from `carrierPeriod`), a reference of exactly n*P for n = 0..4 settles to level n, independent of carrier phase. An upper carrier counts when the reference is strictly greater than it.
- R3: A reference of exactly -n*P for n = 1..4 settles to level -n. A lower carrier counts when the reference is less than or equal to it.
- R4: References beyond +4*P or below -4*P saturate the level at +4 or -4. The level never leaves the range -4..+4.
- R5: `levelCode` moves toward the compared level by at most one step per clock, including when ramping up from 0 after enable returns.
- R6: Gate word for positive levels, written with bit 6 as switch 1 down to bit 0 as switch 7: +1 = 0010100, +2 = 0100100, +3 = 1000100, +4 = 0000110.
- R7: Gate word for negative levels, with the same bit order: -1 = 1001000, -2 = 0101000, -3 = 0011000, -4 = 0001001.
- R8: At level 0 all seven gates are off.
- R9: Switch 5 (bit 2) is on for every positive level and switch 4 (bit 3) for every negative level. The two are never on together.
- R10: The gate word follows the level one clock later. When it changes with a nonzero `deadTime` D, bits turning off clear on that clock. Bits turning on appear D clocks later.
- R11: The shared triangle counts 0 up to P-1 and back down, with a period of 2*(P-1) clocks. For P = 4 and a reference of 2, the level is 1 on exactly half of the clocks. A `carrierPeriod` of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low clears level, gates and carrier |
| refSample | input | REF_W | Signed reference sample |
| carrierPeriod | input | CNT_W | Band height P of each carrier (0 treated as 1) |
| deadTime | input | DT_W | Turn-on delay in clocks |
| gates | output | 7 | Gate bits, bit 6 = switch 1 ... bit 0 = switch 7 |
| levelCode | output | 4 | Signed current output level, two's complement |

## Verification
The bench aims at the band edges, where each reference is an exact multiple of P. An off-by-one in a carrier offset, or a strict-versus-inclusive slip in either comparison, shows up there as a level one step off at some carrier phase. It drives jumps larger than one step, which a missing slew limiter would pass straight through. It crosses the level through zero to catch a swapped polarity switch or a wrong table entry. It checks the dead-time window cycle by cycle: a design that delays the turn-off bits, or releases the turn-on bits a clock early or late, breaks the expected masked word. A triangle with the wrong turning points changes the duty count at P = 4.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

  localparam int NBAND  = 4;
  localparam int LVL_W  = 4;
  localparam int GATE_W = 7;
  localparam int POS_BIT = 2;  // switch 5
  localparam int NEG_BIT = 3;  // switch 4

  typedef struct packed {
    logic run;
    logic countUp;
    logic triHold;
    logic applyDirect;
    logic applyMasked;
    logic gateRelease;
  } pwmCtrl_t;

  typedef struct packed {
    logic atTop;
    logic atBottom;
    logic tgtChanged;
  } pwmStat_t;

  function automatic logic [GATE_W-1:0] levelToGates(input logic signed [LVL_W-1:0] lvl);
    logic [GATE_W-1:0] g;
    case (lvl)
      4'sd1:  g = 7'b0010100;
      4'sd2:  g = 7'b0100100;
      4'sd3:  g = 7'b1000100;
      4'sd4:  g = 7'b0000110;
      -4'sd1: g = 7'b1001000;
      -4'sd2: g = 7'b0101000;
      -4'sd3: g = 7'b0011000;
      -4'sd4: g = 7'b0001001;
      default: g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/mlpwm_ctrl.sv
module mlpwm_ctrl
  import mlpwm_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic [DT_W-1:0] deadTime,
  input  pwmStat_t        stat,
  output pwmCtrl_t        ctrl
);

  logic            dirUpQ;
  logic [DT_W-1:0] dtCnt;

  always_comb begin
    ctrl.run         = enable;
    ctrl.triHold     = stat.atTop && stat.atBottom;
    ctrl.countUp     = dirUpQ ? !stat.atTop : stat.atBottom;
    ctrl.applyDirect = enable && stat.tgtChanged && (deadTime == '0);
    ctrl.applyMasked = enable && stat.tgtChanged && (deadTime != '0);
    ctrl.gateRelease = enable && !stat.tgtChanged && (dtCnt == DT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        dirUpQ <= 1'b1;
    else if (!enable) dirUpQ <= 1'b1;
    else              dirUpQ <= ctrl.countUp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dtCnt <= '0;
    else if (!enable)         dtCnt <= '0;
    else if (stat.tgtChanged) dtCnt <= deadTime;
    else if (dtCnt != '0)     dtCnt <= dtCnt - DT_W'(1);
  end

  AST_DT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (dtCnt == '0)); // R1

endmodule

// File: rtl/mlpwm_datapath.sv
module mlpwm_datapath
  import mlpwm_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [REF_W-1:0] refSample,
  input  logic [CNT_W-1:0]        carrierPeriod,
  input  pwmCtrl_t                ctrl,
  output pwmStat_t                stat,
  output logic [GATE_W-1:0]       gateQ,
  output logic signed [LVL_W-1:0] levelQ
);

  localparam int CMP_W = ((REF_W > CNT_W + 3) ? REF_W : CNT_W + 3) + 1;

  logic [CNT_W-1:0]        triQ;
  logic [CNT_W-1:0]        peakEff;
  logic signed [CMP_W-1:0] refExt;
  logic signed [CMP_W-1:0] peakS;
  logic signed [CMP_W-1:0] triS;
  logic [NBAND-1:0]        upHit;
  logic [NBAND-1:0]        loHit;
  logic signed [LVL_W-1:0] rawLevel;
  logic [GATE_W-1:0]       tgtQ;
  logic [GATE_W-1:0]       tgtNext;

  assign peakEff = (carrierPeriod == '0) ? CNT_W'(1) : carrierPeriod;
  assign refExt  = {{(CMP_W-REF_W){refSample[REF_W-1]}}, refSample};
  assign peakS   = {{(CMP_W-CNT_W){1'b0}}, peakEff};
  assign triS    = {{(CMP_W-CNT_W){1'b0}}, triQ};

  // one triangle, band offsets added per carrier: all carriers stay in phase
  for (genvar k = 0; k < NBAND; k++) begin : g_band
    localparam logic signed [CMP_W-1:0] KMUL = CMP_W'(k);
    logic signed [CMP_W-1:0] baseK;
    assign baseK    = peakS * KMUL;
    assign upHit[k] = refExt > (baseK + triS);
    assign loHit[k] = refExt <= (triS - baseK - peakS);
  end

  assign rawLevel = LVL_W'($countones(upHit) - $countones(loHit));

  assign stat.atTop      = (triQ >= (peakEff - CNT_W'(1)));
  assign stat.atBottom   = (triQ == '0);
  assign tgtNext         = levelToGates(levelQ);
  assign stat.tgtChanged = (tgtNext != tgtQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              triQ <= '0;
    else if (!ctrl.run)     triQ <= '0;
    else if (ctrl.triHold)  triQ <= triQ;
    else if (ctrl.countUp)  triQ <= triQ + CNT_W'(1);
    else                    triQ <= triQ - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   levelQ <= '0;
    else if (!ctrl.run)          levelQ <= '0;
    else if (rawLevel > levelQ)  levelQ <= levelQ + 4'sd1;
    else if (rawLevel < levelQ)  levelQ <= levelQ - 4'sd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtQ  <= '0;
      gateQ <= '0;
    end else if (!ctrl.run) begin
      tgtQ  <= '0;
      gateQ <= '0;
    end else if (ctrl.applyDirect) begin
      tgtQ  <= tgtNext;
      gateQ <= tgtNext;
    end else if (ctrl.applyMasked) begin
      tgtQ  <= tgtNext;
      gateQ <= gateQ & tgtNext;
    end else if (ctrl.gateRelease) begin
      gateQ <= tgtQ;
    end
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.run |=> (levelQ == '0 && gateQ == '0 && triQ == '0)); // R1
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (levelQ >= -4'sd4) && (levelQ <= 4'sd4)); // R4
  AST_LEVEL_SLEW: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.run |=> ((levelQ == $past(levelQ)) || (levelQ == $past(levelQ) + 4'sd1) || (levelQ == $past(levelQ) - 4'sd1))); // R5
  AST_ZERO_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.run && levelQ == '0) |=> (gateQ == '0)); // R8
  AST_POLARITY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(gateQ[POS_BIT] && gateQ[NEG_BIT])); // R9
  AST_GATE_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    (gateQ & ~tgtQ) == '0); // R10
  AST_DEAD_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.run && ctrl.applyMasked) |=> ((gateQ & ~$past(gateQ)) == '0)); // R10

endmodule

// File: rtl/mlpwm_top.sv
module mlpwm_top
  import mlpwm_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CNT_W = 8,
  parameter int DT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic signed [REF_W-1:0] refSample,
  input  logic [CNT_W-1:0]        carrierPeriod,
  input  logic [DT_W-1:0]         deadTime,
  output logic [GATE_W-1:0]       gates,
  output logic signed [LVL_W-1:0] levelCode
);

  pwmCtrl_t ctrl;
  pwmStat_t stat;

  mlpwm_ctrl #(.DT_W(DT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .deadTime (deadTime),
    .stat     (stat),
    .ctrl     (ctrl)
  );

  mlpwm_datapath #(.REF_W(REF_W), .CNT_W(CNT_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .refSample     (refSample),
    .carrierPeriod (carrierPeriod),
    .ctrl          (ctrl),
    .stat          (stat),
    .gateQ         (gates),
    .levelQ        (levelCode)
  );

endmodule

// File: tb/mlpwm_top_bench.sv
module mlpwm_top_bench;

  localparam int REF_W = 12;
  localparam int CNT_W = 8;
  localparam int DT_W  = 4;
  localparam int NV    = 12;

  localparam int VREF [NV] = '{0, 16, 32, 48, 64, 100, -16, -32, -48, -64, -300, 0};
  localparam int VLEV [NV] = '{0, 1, 2, 3, 4, 4, -1, -2, -3, -4, -4, 0};
  localparam int VSAT [NV] = '{0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0};
  localparam logic [6:0] VGATE [NV] = '{7'b0000000, 7'b0010100, 7'b0100100, 7'b1000100,
                                        7'b0000110, 7'b0000110, 7'b1001000, 7'b0101000,
                                        7'b0011000, 7'b0001001, 7'b0001001, 7'b0000000};

  logic                    clk = 1'b0;
  logic                    rstN;
  logic                    enable;
  logic signed [REF_W-1:0] refSample;
  logic [CNT_W-1:0]        carrierPeriod;
  logic [DT_W-1:0]         deadTime;
  logic [6:0]              gates;
  logic signed [3:0]       levelCode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mlpwm_top #(.REF_W(REF_W), .CNT_W(CNT_W), .DT_W(DT_W)) u_mlpwm_top (
    .clk(clk), .rstN(rstN), .enable(enable), .refSample(refSample),
    .carrierPeriod(carrierPeriod), .deadTime(deadTime),
    .gates(gates), .levelCode(levelCode)
  );

  task automatic checkInt(input string req, input string what, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int ones;
    rstN = 1'b0; enable = 1'b0; refSample = '0; carrierPeriod = 8'd16; deadTime = '0;
    waitNeg(3);
    checkInt("R1", "reset level", int'(levelCode), 0);
    checkInt("R1", "reset gates", int'(gates), 0);
    rstN = 1'b1; enable = 1'b1;
    waitNeg(2);

    // vector walk: P = 16, no dead time
    for (int i = 0; i < NV; i++) begin
      string lt, gt;
      refSample = REF_W'(VREF[i]);
      waitNeg(12);
      lt = (VSAT[i] != 0) ? "R4" : ((VLEV[i] < 0) ? "R3" : "R2");
      gt = (VLEV[i] > 0) ? "R6" : ((VLEV[i] < 0) ? "R7" : "R8");
      checkInt(lt, "level", int'(levelCode), VLEV[i]);
      checkInt(gt, "gates", int'(gates), int'(VGATE[i]));
      checkInt("R9", "switch5", int'(gates[2]), (VLEV[i] > 0) ? 1 : 0);
      checkInt("R9", "switch4", int'(gates[3]), (VLEV[i] < 0) ? 1 : 0);
    end

    // R5 slew: 0 to +4 one step per clock
    refSample = '0;
    waitNeg(12);
    refSample = REF_W'(64);
    for (int s = 1; s <= 4; s++) begin
      waitNeg(1);
      checkInt("R5", "ramp level", int'(levelCode), s);
    end
    checkInt("R10", "gates lag level", int'(gates), int'(7'b1000100));

    // R10 dead time 3: +1 -> +2
    refSample = REF_W'(16);
    waitNeg(12);
    deadTime = 4'd3;
    refSample = REF_W'(32);
    waitNeg(1);
    checkInt("R10", "before apply", int'(gates), int'(7'b0010100));
    waitNeg(1);
    checkInt("R10", "off drops at once", int'(gates), int'(7'b0000100));
    waitNeg(2);
    checkInt("R10", "on still held", int'(gates), int'(7'b0000100));
    waitNeg(1);
    checkInt("R10", "on released", int'(gates), int'(7'b0100100));
    deadTime = '0;

    // R1 disable, then R5 restart from zero
    refSample = REF_W'(64);
    waitNeg(12);
    enable = 1'b0;
    waitNeg(1);
    checkInt("R1", "disabled level", int'(levelCode), 0);
    checkInt("R1", "disabled gates", int'(gates), 0);
    enable = 1'b1;
    waitNeg(1);
    checkInt("R5", "restart level", int'(levelCode), 1);

    // R11 triangle duty at P = 4, ref = 2
    enable = 1'b0; carrierPeriod = 8'd4; refSample = REF_W'(2);
    waitNeg(1);
    enable = 1'b1;
    waitNeg(20);
    ones = 0;
    for (int c = 0; c < 60; c++) begin
      waitNeg(1);
      if (levelCode == 4'sd1) ones++;
    end
    checkInt("R11", "level-1 clocks of 60", ones, 30);

    // R11 period 0 acts as 1
    enable = 1'b0; carrierPeriod = '0; refSample = REF_W'(1);
    waitNeg(1);
    enable = 1'b1;
    waitNeg(10);
    checkInt("R11", "zero period level", int'(levelCode), 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule